// File: doc/BRIEF.md
# Two-Channel Daisy-Chain Nested Interrupt Controller

This block is the interrupt half of a two-channel peripheral that shares one interrupt line with other devices strung along a priority chain. Each channel raises a one-cycle request strobe. The block then pulls its active-low interrupt request whenever the chain grants it permission. On a single-cycle acknowledge strobe, it returns the 8-bit vector of the winning channel. Position in the chain decides priority: a device only sees a high enable-in when every device nearer the host is idle. Inside the block, channel A ranks above channel B.

A channel stays under service from its acknowledge until the host executes its return-from-interrupt instruction. While a channel is under service, the block holds its enable-out low, so every device further down the chain stays silent. A higher-ranked source may still nest on top of it.

No end-of-interrupt wire exists. The block snoops opcode fetches on the host data bus and treats the byte pair 0xED then 0x4D on two successive fetch strobes as the return. Only the highest-ranked channel that is under service and has a high enable-in is released by each return.

Top module: `daisy_irq_ctl`

## Requirements
- R1: After reset nothing is pending or under service: `intReqN` is 1, `vecValid` is 0 and `chainOut` equals `chainIn`.
- R2: A request strobe on a channel, with `chainIn` high and nothing of equal or higher rank busy, drives `intReqN` to 0 from the cycle after the strobe.
- R3: While `chainIn` is 0 the block never asserts `intReqN`, even with requests pending.
- R4: `chainOut` is 0 whenever `chainIn` is 0 or any channel is pending or under service; otherwise it is 1.
- R5: When both channels are pending, an acknowledge serves channel A first.
- R6: The cycle after an accepted `ackStb`, `vecValid` is 1 for one cycle and `vecOut` carries the served channel's vector with bit 0 forced to 0. `vecOut` keeps that value until the next accepted acknowledge.
- R7: A channel-B request does not assert `intReqN` while channel A is under service; it does so once A has been released.
- R8: A channel-A request asserts `intReqN` while channel B is under service (nesting).
- R9: A return is recognised only when a fetch strobe carrying 0xED is followed by the next fetch strobe carrying 0x4D; cycles without a fetch strobe between them do not break the pair, and any other fetched byte between them does.
- R10: Each return releases only the highest-ranked channel under service, so nested services unwind A first, then B.
- R11: A return seen while `chainIn` is 0 releases no channel.
- R12: An `ackStb` while the block is not asserting `intReqN` produces no `vecValid` and changes no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqA | input | 1 | Channel A request strobe |
| reqB | input | 1 | Channel B request strobe |
| vecWrA | input | 1 | Load `vecData` as channel A vector |
| vecWrB | input | 1 | Load `vecData` as channel B vector |
| vecData | input | 8 | Vector load value |
| chainIn | input | 1 | Priority enable from the upstream device |
| chainOut | output | 1 | Priority enable to the downstream device |
| intReqN | output | 1 | Interrupt request, active low |
| ackStb | input | 1 | Interrupt acknowledge strobe |
| fetchStb | input | 1 | Host opcode fetch strobe |
| busData | input | 8 | Host data bus, sampled on `fetchStb` |
| vecOut | output | 8 | Vector returned for the acknowledge |
| vecValid | output | 1 | `vecOut` updated by an acknowledge this cycle |

## Verification
The single-channel pattern checks request, acknowledge, vector and release timing. The simultaneous A+B pattern separates correct internal ranking from a plain first-come order. The B-then-A nesting pattern, with a fresh B request between the two returns, shows which channel a return releases. Holding `chainIn` low during requests, acknowledges and returns shows the upstream gating. Return sequences with idle gaps and with an interloping byte show the fetch-pair matcher accepting and rejecting the right patterns.

// File: rtl/daisy_irq_pkg.sv
package daisy_irq_pkg;
  localparam int CH_N = 2;
  localparam int CH_W = (CH_N > 1) ? $clog2(CH_N) : 1;

  // strobes from control to datapath
  typedef struct packed {
    logic [CH_N-1:0] grant;   // one-hot: channel acknowledged this cycle
  } ctlStrobes_t;
endpackage

// File: rtl/daisy_irq_ctrl.sv
module daisy_irq_ctrl
  import daisy_irq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] RET_PREFIX = 8'hED,
  parameter logic [DATA_W-1:0] RET_OPCODE = 8'h4D
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CH_N-1:0]   reqIn,
  input  logic              chainIn,
  input  logic              ackStb,
  input  logic              fetchStb,
  input  logic [DATA_W-1:0] busData,
  output logic              intReqN,
  output logic              chainOut,
  output ctlStrobes_t       strobes
);
  logic [CH_N-1:0] pend, serv;
  logic [CH_N-1:0] chanEn, active, servEn, retClr;
  logic            sawPrefix, retHit, chainRun;

  // internal enable chain: index 0 (channel A) is nearest the host
  always_comb begin
    logic run;
    run = chainIn;
    for (int i = 0; i < CH_N; i++) begin
      chanEn[i] = run;
      run       = run & ~pend[i] & ~serv[i];
    end
    chainRun = run;
  end

  assign active        = chanEn & pend & ~serv;
  assign servEn        = chanEn & serv;
  assign strobes.grant = active & {CH_N{ackStb}};
  assign retClr        = servEn & {CH_N{retHit}};
  assign intReqN       = ~|active;
  assign chainOut      = chainRun;

  // return-from-interrupt snooper on opcode fetches
  assign retHit = fetchStb & sawPrefix & (busData == RET_OPCODE);

  always_ff @(posedge clk) begin
    if (!rstN)         sawPrefix <= 1'b0;
    else if (fetchStb) sawPrefix <= (busData == RET_PREFIX);
  end

  for (genvar g = 0; g < CH_N; g++) begin : g_chan
    always_ff @(posedge clk) begin
      if (!rstN) begin
        pend[g] <= 1'b0;
        serv[g] <= 1'b0;
      end else begin
        pend[g] <= reqIn[g] | (pend[g] & ~strobes.grant[g]);
        serv[g] <= strobes.grant[g] | (serv[g] & ~retClr[g]);
      end
    end
  end
endmodule

// File: rtl/daisy_irq_dp.sv
module daisy_irq_dp
  import daisy_irq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CH_N-1:0]   vecWr,
  input  logic [DATA_W-1:0] vecData,
  input  ctlStrobes_t       strobes,
  output logic [DATA_W-1:0] vecOut,
  output logic              vecValid
);
  localparam logic [DATA_W-1:0] LSB_CLR = ~{{(DATA_W-1){1'b0}}, 1'b1};

  logic [DATA_W-1:0] vecReg [CH_N];
  logic [DATA_W-1:0] vecSel;

  for (genvar g = 0; g < CH_N; g++) begin : g_vec
    always_ff @(posedge clk) begin
      if (!rstN)         vecReg[g] <= '0;
      else if (vecWr[g]) vecReg[g] <= vecData & LSB_CLR;
    end
  end

  always_comb begin
    vecSel = '0;
    for (int i = 0; i < CH_N; i++)
      if (strobes.grant[i]) vecSel = vecReg[i];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vecOut   <= '0;
      vecValid <= 1'b0;
    end else begin
      vecValid <= |strobes.grant;
      if (|strobes.grant) vecOut <= vecSel;
    end
  end
endmodule

// File: rtl/daisy_irq_ctl.sv
module daisy_irq_ctl
  import daisy_irq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqA,
  input  logic              reqB,
  input  logic              vecWrA,
  input  logic              vecWrB,
  input  logic [DATA_W-1:0] vecData,
  input  logic              chainIn,
  output logic              chainOut,
  output logic              intReqN,
  input  logic              ackStb,
  input  logic              fetchStb,
  input  logic [DATA_W-1:0] busData,
  output logic [DATA_W-1:0] vecOut,
  output logic              vecValid
);
  ctlStrobes_t strobes;

  daisy_irq_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqIn({reqB, reqA}), .chainIn(chainIn),
    .ackStb(ackStb), .fetchStb(fetchStb), .busData(busData),
    .intReqN(intReqN), .chainOut(chainOut), .strobes(strobes)
  );

  daisy_irq_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .vecWr({vecWrB, vecWrA}), .vecData(vecData),
    .strobes(strobes), .vecOut(vecOut), .vecValid(vecValid)
  );
endmodule

// File: rtl/daisy_irq_ctl_chk.sv
module daisy_irq_ctl_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              chainIn,
  input logic              chainOut,
  input logic              intReqN,
  input logic              ackStb,
  input logic [DATA_W-1:0] vecOut,
  input logic              vecValid
);
  a_r4_chain_blocked: assert property (@(posedge clk) disable iff (!rstN)
    !chainIn |-> !chainOut);

  a_r3_no_req_upstream_busy: assert property (@(posedge clk) disable iff (!rstN)
    !chainIn |-> intReqN);

  a_r4_req_blocks_chain: assert property (@(posedge clk) disable iff (!rstN)
    !intReqN |-> !chainOut);

  a_r6_vec_even: assert property (@(posedge clk) disable iff (!rstN)
    vecValid |-> !vecOut[0]);

  a_r6_vec_held: assert property (@(posedge clk) disable iff (!rstN)
    !vecValid |-> $stable(vecOut));

  a_r12_valid_needs_ack: assert property (@(posedge clk) disable iff (!rstN)
    vecValid |-> ($past(ackStb) && !$past(intReqN)));
endmodule

bind daisy_irq_ctl daisy_irq_ctl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .chainIn(chainIn), .chainOut(chainOut),
  .intReqN(intReqN), .ackStb(ackStb), .vecOut(vecOut), .vecValid(vecValid)
);

// File: tb/daisy_irq_ctl_bench.sv
`timescale 1ns/1ps
module daisy_irq_ctl_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reqA = 1'b0, reqB = 1'b0, vecWrA = 1'b0, vecWrB = 1'b0;
  logic [7:0] vecData = '0, busData = '0;
  logic       chainIn = 1'b1, ackStb = 1'b0, fetchStb = 1'b0;
  logic       chainOut, intReqN, vecValid;
  logic [7:0] vecOut;
  int         nChecks = 0, nFails = 0;
  bit         finished = 1'b0;

  localparam logic [7:0] VEC_A = 8'h36;  // loaded as 0x37
  localparam logic [7:0] VEC_B = 8'h80;  // loaded as 0x81

  always #2.5 clk = ~clk;

  daisy_irq_ctl u_daisy_irq_ctl (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // every helper starts and ends at a falling edge
  task automatic tick();
    @(negedge clk);
  endtask
  task automatic pulseReq(input logic a, input logic b);
    reqA = a; reqB = b; tick(); reqA = 0; reqB = 0;
  endtask
  task automatic ack();
    ackStb = 1; tick(); ackStb = 0;
  endtask
  task automatic fetch(input logic [7:0] b);
    fetchStb = 1; busData = b; tick(); fetchStb = 0; busData = '0;
  endtask
  task automatic ret();
    fetch(8'hED); fetch(8'h4D);
  endtask

  task automatic t_reset();
    check("R1 intReqN in reset", intReqN, 1);
    check("R1 vecValid in reset", vecValid, 0);
    rstN = 1; tick();
    check("R1 intReqN after reset", intReqN, 1);
    check("R1 chainOut follows chainIn", chainOut, 1);
    vecWrA = 1; vecData = 8'h37; tick(); vecWrA = 0;
    vecWrB = 1; vecData = 8'h81; tick(); vecWrB = 0; vecData = '0;
    ack();
    check("R12 ack with nothing pending", vecValid, 0);
  endtask

  task automatic t_single_a();
    pulseReq(1, 0);
    check("R2 request asserted", intReqN, 0);
    check("R4 chainOut low while pending", chainOut, 0);
    ack();
    check("R6 vecValid after ack", vecValid, 1);
    check("R6 vector A bit0 cleared", vecOut, VEC_A);
    check("R4 chainOut low in service", chainOut, 0);
    check("R2 request dropped after ack", intReqN, 1);
    tick();
    check("R6 vecValid one cycle", vecValid, 0);
    check("R6 vecOut held", vecOut, VEC_A);
    ret();
    check("R9 return releases A", chainOut, 1);
  endtask

  task automatic t_chain_disabled();
    chainIn = 0;
    pulseReq(0, 1);
    check("R3 no request with chainIn low", intReqN, 1);
    check("R4 chainOut low with chainIn low", chainOut, 0);
    ack();
    check("R12 ack ignored while gated", vecValid, 0);
    chainIn = 1; tick();
    check("R3 request once chainIn high", intReqN, 0);
    ack();
    check("R6 vector B bit0 cleared", vecOut, VEC_B);
    chainIn = 0; ret(); chainIn = 1; tick();
    check("R11 return ignored while gated", chainOut, 0);
    ret();
    check("R11 return releases once enabled", chainOut, 1);
  endtask

  task automatic t_priority();
    pulseReq(1, 1);
    ack();
    check("R5 A served first", vecOut, VEC_A);
    check("R7 B held off while A in service", intReqN, 1);
    ret();
    check("R7 B requests after A released", intReqN, 0);
    ack();
    check("R5 B served second", vecOut, VEC_B);
    ret();
    check("R4 chain free after both", chainOut, 1);
  endtask

  task automatic t_nesting();
    pulseReq(0, 1);
    ack();
    check("R8 B served", vecOut, VEC_B);
    pulseReq(1, 0);
    check("R8 A interrupts B service", intReqN, 0);
    ack();
    check("R8 A vector nested", vecOut, VEC_A);
    ret();
    check("R10 B still in service", chainOut, 0);
    pulseReq(0, 1);
    check("R10 B blocked so B not released", intReqN, 1);
    ret();
    check("R10 second return releases B", intReqN, 0);
    ack();
    check("R10 pending B served", vecOut, VEC_B);
    ret();
    check("R10 chain free", chainOut, 1);
  endtask

  task automatic t_ret_variants();
    pulseReq(1, 0); ack();
    fetch(8'hED); tick(); tick(); fetch(8'h4D);
    check("R9 idle gaps keep the pair", chainOut, 1);
    pulseReq(1, 0); ack();
    fetch(8'hED); fetch(8'h00); fetch(8'h4D);
    check("R9 interloping byte breaks pair", chainOut, 0);
    fetch(8'h4D);
    check("R9 lone second byte ignored", chainOut, 0);
    ret();
    check("R9 clean pair releases", chainOut, 1);
  endtask

  initial begin
    tick(); tick(); tick();
    t_reset();
    t_single_a();
    t_chain_disabled();
    t_priority();
    t_nesting();
    t_ret_variants();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end
endmodule